// File: doc/BRIEF.md
# Register-Controlled Shifter with Carry Flag

This block is a 32-bit shifter for an integer execution stage. Each operation takes a data word, an amount word, a two-bit operation code and the current carry flag. It returns the shifted word and the new carry flag. Only the low byte of the amount word sets the distance. Distances of zero, exactly the word width and above the word width each have their own result and carry for every operation.

Four operations are supported: logical left, logical right, arithmetic right and rotate right. Rotate uses the distance modulo the word width. A nonzero distance that is a whole multiple of the width still updates the carry. A zero distance passes the data and the incoming carry through unchanged.

The result and carry can be registered before they leave the block. The `OUT_REG` parameter selects this and is on by default. With it on, the outputs follow the inputs by one clock.

Top module: `bshift_carry`

## Requirements
- R1: Only bits 7:0 of `amt_i` set the distance n. Bits 31:8 have no effect on the result or the carry.
- R2: If n is 0, the result equals `val_i` and the carry equals `carry_i`, for every operation code.
- R3: Op code 00 is logical left. For n from 1 to 31 the result is `val_i << n` and the carry is `val_i[32-n]`.
- R4: For op code 00 with n = 32, the result is 0 and the carry is `val_i[0]`. For n above 32, the result and the carry are both 0.
- R5: Op code 01 is logical right. For n from 1 to 31 the result is `val_i >> n` and the carry is `val_i[n-1]`.
- R6: For op code 01 with n = 32, the result is 0 and the carry is `val_i[31]`. For n above 32, the result and the carry are both 0.
- R7: Op code 10 is arithmetic right. For n from 1 to 31 the result is the sign-filling shift and the carry is `val_i[n-1]`. For n of 32 or more, every result bit and the carry equal `val_i[31]`.
- R8: Op code 11 is rotate right by r = n mod 32. When r is nonzero, the result is the rotated word and the carry is `val_i[r-1]`.
- R9: For op code 11, when n is nonzero and r is 0, the result equals `val_i` and the carry is `val_i[31]`.
- R10: With `OUT_REG` set, the outputs show the operation one rising clock edge after it is applied. While `rst_ni` is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| val_i | input | 32 | Data word to shift |
| amt_i | input | 32 | Amount word; only the low byte is used |
| op_i | input | 2 | Operation code: 00 LSL, 01 LSR, 10 ASR, 11 ROR |
| carry_i | input | 1 | Incoming carry flag |
| res_o | output | 32 | Shifted result |
| carry_o | output | 1 | New carry flag |

## Verification
The assertions assume that the inputs are known and stable across each rising edge. They compare the registered outputs with the inputs sampled one edge earlier, so they depend on the default registered configuration. The bench changes inputs only on falling edges and holds each operation for a full clock. Random amounts are drawn so that zero, exactly 32, whole multiples of 32 and values up to 255 all occur often. The upper bits of the amount word are always filled with random values.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
  typedef enum logic [1:0] {
    OP_LSL = 2'b00,
    OP_LSR = 2'b01,
    OP_ASR = 2'b10,
    OP_ROR = 2'b11
  } shift_op_e;
endpackage

// File: rtl/bshift_amt_dec.sv
module bshift_amt_dec #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [AMT_W-1:0] amt_i,
  output logic             zero_o,
  output logic             big_o,
  output logic [SH_W-1:0]  rot_o,
  output logic             rot_wrap_o
);
  assign zero_o     = (amt_i == '0);
  assign big_o      = (amt_i >= AMT_W'(DATA_W));
  assign rot_o      = amt_i[SH_W-1:0];
  // nonzero multiple of the width
  assign rot_wrap_o = !zero_o && (rot_o == '0);
endmodule

// File: rtl/bshift_datapath.sv
module bshift_datapath
  import bshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  shift_op_e         op_i,
  input  logic              carry_i,
  input  logic              zero_i,
  input  logic              big_i,
  input  logic [SH_W-1:0]   rot_i,
  input  logic              rot_wrap_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  logic        [DATA_W:0] ext_l, ext_r;
  logic signed [DATA_W:0] ext_a;
  logic        [AMT_W-1:0] amt_sat;
  logic        [DATA_W-1:0] rot_res;

  // one guard bit beside the word catches the last bit shifted out
  assign ext_l   = {1'b0, val_i} << amt_i;
  assign ext_r   = {val_i, 1'b0} >> amt_i;
  assign amt_sat = big_i ? AMT_W'(DATA_W) : amt_i;
  assign ext_a   = $signed({val_i, 1'b0}) >>> amt_sat;
  assign rot_res = DATA_W'({val_i, val_i} >> rot_i);

  always_comb begin
    res_o   = val_i;
    carry_o = carry_i;
    if (!zero_i) begin
      unique case (op_i)
        OP_LSL: begin res_o = ext_l[DATA_W-1:0]; carry_o = ext_l[DATA_W]; end
        OP_LSR: begin res_o = ext_r[DATA_W:1];   carry_o = ext_r[0];      end
        OP_ASR: begin res_o = ext_a[DATA_W:1];   carry_o = ext_a[0];      end
        default: begin
          res_o   = rot_res;
          carry_o = rot_wrap_i ? val_i[DATA_W-1] : val_i[rot_i - SH_W'(1)];
        end
      endcase
    end
  end
endmodule

// File: rtl/bshift_out_stage.sv
module bshift_out_stage #(
  parameter int DATA_W  = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] res_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_o   <= '0;
        carry_o <= 1'b0;
      end else begin
        res_o   <= res_i;
        carry_o <= carry_i;
      end
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign res_o      = res_i;
    assign carry_o    = carry_i;
  end
endmodule

// File: rtl/bshift_carry.sv
module bshift_carry
  import bshift_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int AMT_W   = 8,
  parameter bit OUT_REG = 1'b1,
  localparam int SH_W   = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] val_i,
  input  logic [DATA_W-1:0] amt_i,
  input  logic [1:0]        op_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  logic [AMT_W-1:0]  amt_b;
  logic              zero, big, rot_wrap;
  logic [SH_W-1:0]   rot;
  logic [DATA_W-1:0] res_c;
  logic              carry_c;
  logic              unused_hi;

  assign amt_b     = amt_i[AMT_W-1:0];
  assign unused_hi = ^amt_i[DATA_W-1:AMT_W];  // R1: upper bits dropped

  bshift_amt_dec #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_dec (
    .amt_i(amt_b), .zero_o(zero), .big_o(big), .rot_o(rot), .rot_wrap_o(rot_wrap)
  );

  bshift_datapath #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_dp (
    .val_i(val_i), .amt_i(amt_b), .op_i(shift_op_e'(op_i)), .carry_i(carry_i),
    .zero_i(zero), .big_i(big), .rot_i(rot), .rot_wrap_i(rot_wrap),
    .res_o(res_c), .carry_o(carry_c)
  );

  bshift_out_stage #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .res_i(res_c), .carry_i(carry_c),
    .res_o(res_o), .carry_o(carry_o)
  );

  if (OUT_REG) begin : g_chk
    p_zero_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (amt_i[AMT_W-1:0] == '0) |=> (res_o == $past(val_i) && carry_o == $past(carry_i)));
    p_lsl_over_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == 2'b00 && amt_i[AMT_W-1:0] > AMT_W'(DATA_W)) |=> (res_o == '0 && !carry_o));
    p_lsr_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == 2'b01 && amt_i[AMT_W-1:0] == AMT_W'(DATA_W))
        |=> (res_o == '0 && carry_o == $past(val_i[DATA_W-1])));
    p_asr_sign_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == 2'b10 && amt_i[AMT_W-1:0] >= AMT_W'(DATA_W))
        |=> (res_o == {DATA_W{$past(val_i[DATA_W-1])}} && carry_o == $past(val_i[DATA_W-1])));
    p_ror_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == 2'b11 && amt_i[AMT_W-1:0] != '0 && amt_i[SH_W-1:0] == '0)
        |=> (res_o == $past(val_i) && carry_o == $past(val_i[DATA_W-1])));
    p_reset_clear_r10: assert property (@(posedge clk_i)
      !rst_ni |-> (res_o == '0 && !carry_o));
  end
endmodule

// File: tb/bshift_carry_test.sv
module bshift_carry_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] val = '0, amt = '0;
  logic [1:0]  op = '0;
  logic        cin = 1'b0;
  logic [31:0] res;
  logic        cout;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bshift_carry uut (
    .clk_i(clk), .rst_ni(rst_n), .val_i(val), .amt_i(amt), .op_i(op),
    .carry_i(cin), .res_o(res), .carry_o(cout)
  );

  // returns {carry, result}, built by one-bit steps
  function automatic logic [32:0] model(logic [31:0] v, logic [31:0] a, logic [1:0] k, logic c);
    int n = int'(a[7:0]);
    logic [31:0] r = v;
    logic cy = c;
    if (n == 0) return {c, v};
    case (k)
      2'b00: for (int i = 0; i < n; i++) begin cy = r[31]; r = {r[30:0], 1'b0}; end
      2'b01: for (int i = 0; i < n; i++) begin cy = r[0]; r = {1'b0, r[31:1]}; end
      2'b10: for (int i = 0; i < n; i++) begin cy = r[0]; r = {r[31], r[31:1]}; end
      default: begin
        if (n % 32 == 0) cy = v[31];
        else for (int i = 0; i < n % 32; i++) begin cy = r[0]; r = {r[0], r[31:1]}; end
      end
    endcase
    return {cy, r};
  endfunction

  function automatic string tag(logic [31:0] a, logic [1:0] k);
    int n = int'(a[7:0]);
    if (n == 0) return "R2";
    case (k)
      2'b00: return (n < 32) ? "R3" : "R4";
      2'b01: return (n < 32) ? "R5" : "R6";
      2'b10: return "R7";
      default: return (n % 32 == 0) ? "R9" : "R8";
    endcase
  endfunction

  task automatic run(logic [31:0] v, logic [31:0] a, logic [1:0] k, logic c, string t);
    logic [32:0] exp;
    @(negedge clk);
    val = v; amt = a; op = k; cin = c;
    exp = model(v, a, k, c);
    @(negedge clk);
    checks++;
    if ({cout, res} !== exp) begin
      fails++;
      $display("FAIL %s op=%b amt=%h val=%h: got c=%b r=%h exp c=%b r=%h",
               t, k, a, v, cout, res, exp[32], exp[31:0]);
    end
  endtask

  task automatic auto_run(logic [31:0] v, logic [31:0] a, logic [1:0] k, logic c);
    run(v, a, k, c, tag(a, k));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7731));
    val = 32'hdead_beef; amt = 32'd5; op = 2'b01; cin = 1'b1;
    repeat (3) @(negedge clk);
    checks++;  // R10 reset state
    if (res !== '0 || cout !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset: got c=%b r=%h exp c=0 r=0", cout, res);
    end
    rst_n = 1'b1;

    // R10 one-edge latency
    @(negedge clk);
    val = 32'h8000_0001; amt = 32'd1; op = 2'b00; cin = 1'b0;
    @(posedge clk); #1;
    checks++;
    if (res !== 32'h2 || cout !== 1'b1) begin
      fails++;
      $display("FAIL R10 latency: got c=%b r=%h exp c=1 r=00000002", cout, res);
    end

    // directed corners
    for (int k = 0; k < 4; k++) begin
      auto_run(32'h8421_0f0f, 32'h0, 2'(k), 1'b1);           // R2
      auto_run(32'h8421_0f0f, 32'hffff_ff00, 2'(k), 1'b0);   // R2 with high bits
      auto_run(32'h8421_0f0f, 32'd1, 2'(k), 1'b0);
      auto_run(32'h8421_0f0f, 32'd31, 2'(k), 1'b0);
      auto_run(32'h8421_0f0f, 32'd32, 2'(k), 1'b0);
      auto_run(32'h8421_0f0f, 32'd33, 2'(k), 1'b1);
      auto_run(32'h7421_0f0e, 32'd32, 2'(k), 1'b1);
      auto_run(32'h8421_0f0f, 32'd64, 2'(k), 1'b0);
      auto_run(32'h8421_0f0f, 32'd255, 2'(k), 1'b1);
      auto_run(32'h0000_0001, 32'd96, 2'(k), 1'b0);
    end
    run(32'h0000_0001, 32'd32, 2'b00, 1'b0, "R4");
    run(32'h8000_0000, 32'd32, 2'b01, 1'b0, "R6");
    run(32'h8000_0000, 32'd200, 2'b10, 1'b0, "R7");
    run(32'h1234_5678, 32'd160, 2'b11, 1'b0, "R9");
    // R1: same low byte, different upper bits
    run(32'hc001_d00d, 32'h0000_0007, 2'b11, 1'b0, "R1");
    run(32'hc001_d00d, 32'hffab_cd07, 2'b11, 1'b0, "R1");
    run(32'hc001_d00d, 32'h8000_0020, 2'b00, 1'b1, "R1");
    run(32'hc001_d00d, 32'h7f00_0000, 2'b10, 1'b1, "R1");

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] lo;
      case ($urandom_range(0, 5))
        0: lo = 8'd0;
        1: lo = 8'd32;
        2: lo = 8'(32 * $urandom_range(1, 7));
        3: lo = 8'($urandom_range(1, 31));
        4: lo = 8'($urandom_range(33, 255));
        default: lo = 8'($urandom);
      endcase
      auto_run($urandom, {24'($urandom), lo}, 2'($urandom), 1'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule